// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM with a 16-bit common data bus. It accepts one request at a time on a valid/ready interface, turns it into a complete memory bus cycle and, for reads, returns the data on a one-cycle response strobe. Every analog timing limit of the memory (cycle time, access time, write pulse, data setup, bus release) is given as a parameter in nanoseconds. The block rounds each of them up to whole clock periods, so the same code serves any clock rate.

The host request carries a write flag, an address, write data and two lane enables. In word mode the low address bits select a 16-bit word and the lane enables choose which byte lanes take part. In byte mode, chosen per request by `cfg_byte_mode`, the request address is a byte address. Its top bits go on the memory address pins and its bit 0 goes out on the top data pin, DQ15, which the memory reads as its lowest address bit in that mode. Data then moves only on DQ0-7.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The host must hold its request fields stable until that edge. `rsp_valid` has no ready: the host must accept it in the cycle it appears. The data bus leaves the block as separate output, output-enable and input vectors, so the pad ring can build the tristate.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and after reset, before any request: chip select (`sram_cs1_n`), `sram_we_n` and `sram_oe_n` are high, `sram_dq_oe` is zero, `rsp_valid` is low and `req_ready` is high. `sram_cs2` is high at all times.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after acceptance and stays low until the access and any recovery window are over.
- R3: A read holds chip select and `sram_oe_n` low, with a stable address, for RD cycles. RD is the largest of the rounded-up read cycle, address access and output-enable access times (18 cycles at defaults). The bus is sampled on the last of these cycles. `rsp_valid` is high for exactly one cycle, RD cycles after the accepting edge.
- R4: Word-mode lane select: `sram_lb_n` is the inverse of `req_be[0]` (DQ0-7) and `sram_ub_n` is the inverse of `req_be[1]` (DQ8-15). Read data on a lane that was not enabled is returned as zero.
- R5: A write keeps `sram_oe_n` high. It holds `sram_we_n` low for WL cycles (17 at defaults). WL is at least the rounded-up write pulse, the address-to-end-of-write time, the turnaround plus data setup, and the write cycle time less one. After that comes one release cycle with `sram_we_n` high while chip select and the write data are still driven.
- R6: During a write, `sram_dq_oe` stays zero for the first T cycles of the write pulse, where T is the rounded-up bus release time (7 at defaults). After that it enables only the selected data lanes.
- R7: A word write with both lane enables zero finishes the handshake normally but leaves memory contents unchanged.
- R8: After every read, `req_ready` stays low for T cycles, counted from the cycle in which `rsp_valid` is high.
- R9: In byte mode, `sram_byte_n` is low, both lane selects are low whatever `req_be` is, `sram_addr` is `req_addr[20:1]`, and DQ15 is driven with `req_addr[0]` for the whole access. Write data goes only on DQ0-7, and read data is `{8'h00, DQ0-7}`.
- R10: In word mode, `sram_addr` is `req_addr[19:0]` and `req_addr[20]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_mode | input | 1 | Selects 8-bit access for the request being accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address in bits 19:0, or byte address in bits 20:0 |
| req_wdata | input | 16 | Write data (bits 7:0 only in byte mode) |
| req_be | input | 2 | Lane enables, bit 0 = DQ0-7, bit 1 = DQ8-15 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high select, held high |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_lb_n | output | 1 | Active-low low lane select |
| sram_ub_n | output | 1 | Active-low high lane select |
| sram_byte_n | output | 1 | Active-low 8-bit mode select |
| sram_addr | output | 20 | Memory address |
| sram_dq_o | output | 16 | Data bus output value |
| sram_dq_oe | output | 16 | Per-bit data bus drive enable |
| sram_dq_i | input | 16 | Data bus input value |

## Verification
The memory model in the bench returns garbage until a full 70 ns has passed with the address and output enable steady. A read window one cycle too short therefore returns wrong data. The model also fills disabled lanes with a filler pattern, so a missing lane mask shows up in the response. The model counts the write pulse, the data setup and the release cycle at the point where each write ends. It also flags any bus drive that starts inside the turnaround window after the memory stopped driving or after write enable fell. Other checks measure the hold-off after each read, and run a zero-lane write followed by read-back, byte writes to both halves of one word, and a word read with the top request address bit set. Together they catch a hold-off of the wrong length, a write that is committed anyway, swapped halves, or a leaked address bit.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RHOLD,
    ST_WRITE,
    ST_WREL
  } seq_st_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 18,
  parameter int WLOW_CYC = 17,
  parameter int TURN_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic cs_act,
  output logic oe_act,
  output logic we_act,
  output logic drv_act,
  output logic rd_done
);

  localparam int CNT_MAX = max2(max2(RD_CYC, WLOW_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  // counter value at and below which write data may be driven
  localparam int DRV_AT  = WLOW_CYC - 1 - TURN_CYC;

  seq_st_e            state;
  logic [CNT_W-1:0]   cnt;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && (state == ST_IDLE);
  assign cs_act    = (state == ST_READ) || (state == ST_WRITE) || (state == ST_WREL);
  assign oe_act    = (state == ST_READ);
  assign we_act    = (state == ST_WRITE);
  assign drv_act   = ((state == ST_WRITE) && (cnt <= CNT_W'(DRV_AT))) || (state == ST_WREL);
  assign rd_done   = (state == ST_READ) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (req_write) begin
              state <= ST_WRITE;
              cnt   <= CNT_W'(WLOW_CYC - 1);
            end else begin
              state <= ST_READ;
              cnt   <= CNT_W'(RD_CYC - 1);
            end
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            state <= ST_RHOLD;
            cnt   <= CNT_W'(TURN_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RHOLD: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_WRITE: begin
          if (cnt == '0) state <= ST_WREL;
          else           cnt   <= cnt - 1'b1;
        end
        ST_WREL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                  byte_mode,
  input  logic [ADDR_W:0]       haddr,
  input  logic [1:0]            be,
  input  logic [2*LANE_W-1:0]   wdata,
  output logic [ADDR_W-1:0]     maddr,
  output logic                  lb_n,
  output logic                  ub_n,
  output logic [2*LANE_W-1:0]   lane_mask,
  output logic [2*LANE_W-1:0]   dq_wr
);

  localparam int DQ_W = 2 * LANE_W;
  localparam logic [DQ_W-1:0] BYTE_MASK = {{LANE_W{1'b0}}, {LANE_W{1'b1}}};

  logic [DQ_W-1:0] word_mask;
  logic [DQ_W-1:0] byte_wr;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign word_mask[g*LANE_W +: LANE_W] = {LANE_W{be[g]}};
  end

  // top data pin carries the byte-address LSB in 8-bit mode
  assign byte_wr = {haddr[0], {(DQ_W-LANE_W-1){1'b0}}, wdata[LANE_W-1:0]};

  always_comb begin
    if (byte_mode) begin
      maddr     = haddr[ADDR_W:1];
      lb_n      = 1'b0;
      ub_n      = 1'b0;
      lane_mask = BYTE_MASK;
      dq_wr     = byte_wr;
    end else begin
      maddr     = haddr[ADDR_W-1:0];
      lb_n      = ~be[0];
      ub_n      = ~be[1];
      lane_mask = word_mask;
      dq_wr     = wdata;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_done,
  input  logic [DQ_W-1:0] mask,
  input  logic [DQ_W-1:0] dq_i,
  output logic            rsp_valid,
  output logic [DQ_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= dq_i & mask;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS    = 4,
  parameter int ADDR_W    = 20,
  parameter int LANE_W    = 8,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 55,
  parameter int T_AW_NS   = 65,
  parameter int T_DW_NS   = 35,
  parameter int T_TURN_NS = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_byte_mode,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W:0]       req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_be,
  output logic                  rsp_valid,
  output logic [2*LANE_W-1:0]   rsp_rdata,
  output logic                  sram_cs1_n,
  output logic                  sram_cs2,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic                  sram_lb_n,
  output logic                  sram_ub_n,
  output logic                  sram_byte_n,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic [2*LANE_W-1:0]   sram_dq_o,
  output logic [2*LANE_W-1:0]   sram_dq_oe,
  input  logic [2*LANE_W-1:0]   sram_dq_i
);

  localparam int DQ_W     = 2 * LANE_W;
  localparam int TURN_CYC = max2(1, ns_to_cyc(T_TURN_NS, CLK_NS));
  localparam int RD_CYC   = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                 max2(ns_to_cyc(T_OE_NS, CLK_NS), 1));
  localparam int WLOW_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                 max2(TURN_CYC + max2(1, ns_to_cyc(T_DW_NS, CLK_NS)),
                                      ns_to_cyc(T_WC_NS, CLK_NS) - 1));
  localparam logic [DQ_W-1:0] ADDR_PIN = {1'b1, {(DQ_W-1){1'b0}}};

  logic accept, cs_act, oe_act, we_act, drv_act, rd_done;

  logic [ADDR_W-1:0] map_addr;
  logic              map_lb_n, map_ub_n;
  logic [DQ_W-1:0]   map_mask, map_wr;

  logic [ADDR_W-1:0] addr_q;
  logic              lb_q, ub_q, bmode_q;
  logic [DQ_W-1:0]   mask_q, wr_q;

  sram_seq_fsm #(
    .RD_CYC  (RD_CYC),
    .WLOW_CYC(WLOW_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .cs_act   (cs_act),
    .oe_act   (oe_act),
    .we_act   (we_act),
    .drv_act  (drv_act),
    .rd_done  (rd_done)
  );

  sram_lane_map #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W)
  ) u_map (
    .byte_mode(cfg_byte_mode),
    .haddr    (req_addr),
    .be       (req_be),
    .wdata    (req_wdata),
    .maddr    (map_addr),
    .lb_n     (map_lb_n),
    .ub_n     (map_ub_n),
    .lane_mask(map_mask),
    .dq_wr    (map_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      lb_q    <= 1'b1;
      ub_q    <= 1'b1;
      bmode_q <= 1'b0;
      mask_q  <= '0;
      wr_q    <= '0;
    end else if (accept) begin
      addr_q  <= map_addr;
      lb_q    <= map_lb_n;
      ub_q    <= map_ub_n;
      bmode_q <= cfg_byte_mode;
      mask_q  <= map_mask;
      wr_q    <= map_wr;
    end
  end

  sram_rd_capture #(
    .DQ_W(DQ_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_done  (rd_done),
    .mask     (mask_q),
    .dq_i     (sram_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  assign sram_cs1_n  = ~cs_act;
  assign sram_cs2    = 1'b1;
  assign sram_we_n   = ~we_act;
  assign sram_oe_n   = ~oe_act;
  assign sram_lb_n   = lb_q;
  assign sram_ub_n   = ub_q;
  assign sram_byte_n = ~bmode_q;
  assign sram_addr   = addr_q;
  assign sram_dq_o   = wr_q;
  assign sram_dq_oe  = ({DQ_W{drv_act}} & mask_q) | ({DQ_W{bmode_q & cs_act}} & ADDR_PIN);

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                sram_cs1_n,
  input logic                sram_we_n,
  input logic                sram_oe_n,
  input logic                sram_lb_n,
  input logic                sram_ub_n,
  input logic                sram_byte_n,
  input logic [ADDR_W-1:0]   sram_addr,
  input logic [2*LANE_W-1:0] sram_dq_oe
);

  localparam int DQ_W = 2 * LANE_W;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (sram_cs1_n && sram_we_n && sram_oe_n && (sram_dq_oe == '0) && !rsp_valid));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  rd_addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

  // R3
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  wr_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  // R6
  wr_turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(sram_we_n)) |-> (sram_dq_oe[DQ_W-2:0] == '0));

  // R8
  rd_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9
  byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_byte_n && !sram_cs1_n) |-> (!sram_lb_n && !sram_ub_n && sram_dq_oe[DQ_W-1]));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .LANE_W(LANE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_cs1_n (sram_cs1_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_lb_n  (sram_lb_n),
  .sram_ub_n  (sram_ub_n),
  .sram_byte_n(sram_byte_n),
  .sram_addr  (sram_addr),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;

  localparam int CLK_NS = 4;

  function automatic int cyc_of(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int RDC = cyc_of(70);   // read window
  localparam int TRN = cyc_of(25);   // bus release
  localparam int WPC = cyc_of(55);   // write pulse
  localparam int AWC = cyc_of(65);   // address to end of write
  localparam int DWC = cyc_of(35);   // data setup

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bm = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        cs1_n, cs2, we_n, oe_n, lb_n, ub_n, byte_n;
  logic [19:0] maddr;
  logic [15:0] dq_o, dq_oe;
  logic [15:0] dq_i = 16'h5A5A;

  sram_cycle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_byte_mode(bm),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_cs1_n(cs1_n), .sram_cs2(cs2), .sram_we_n(we_n), .sram_oe_n(oe_n),
    .sram_lb_n(lb_n), .sram_ub_n(ub_n), .sram_byte_n(byte_n),
    .sram_addr(maddr), .sram_dq_o(dq_o), .sram_dq_oe(dq_oe), .sram_dq_i(dq_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int commits = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [int];
  int          rd_cnt = 0;
  logic [20:0] rd_key = '0;
  int          quiet = 100;
  int          wcnt = 0, dcnt = 0;
  logic [15:0] w_dat, w_req;
  logic [19:0] w_addr;
  logic        w_bm, w_lb, w_ub;

  always @(negedge clk) begin
    logic        mdrv, wact;
    logic [15:0] word, req_lanes;
    logic [20:0] key;
    mdrv = !cs1_n && !oe_n && we_n;
    wact = !cs1_n && !we_n && (!lb_n || !ub_n);
    key  = {maddr, !byte_n ? dq_o[15] : 1'b0};
    // bus ownership
    if (dq_oe != 16'h0) begin
      if (mdrv && (byte_n || dq_oe[14:0] != 15'h0))
        chk(1'b0, "R6 contention", dq_oe, 32'h0);
      else if (!mdrv && quiet < TRN && (dq_oe & 16'h7FFF) != 16'h0)
        chk(1'b0, "R6 release gap", quiet, TRN);
    end
    // read side
    if (mdrv) begin
      if (rd_cnt > 0 && key == rd_key) rd_cnt++;
      else rd_cnt = 1;
      rd_key = key;
      word = mem.exists(int'(maddr)) ? mem[int'(maddr)] : 16'h0;
      if (rd_cnt < RDC) dq_i <= 16'hBAD0;
      else if (!byte_n) dq_i <= {8'hA5, dq_o[15] ? word[15:8] : word[7:0]};
      else dq_i <= {ub_n ? 8'hA5 : word[15:8], lb_n ? 8'hA5 : word[7:0]};
      quiet = 0;
    end else begin
      rd_cnt = 0;
      dq_i <= 16'h5A5A;
      quiet++;
    end
    // write side
    req_lanes = !byte_n ? 16'h00FF : {{8{!ub_n}}, {8{!lb_n}}};
    if (wact) begin
      wcnt++;
      if (!oe_n) chk(1'b0, "R5 oe during write", oe_n, 1);
      if (wcnt <= TRN && (dq_oe & 16'h7FFF) != 16'h0) chk(1'b0, "R6 early drive", dq_oe, 0);
      if ((dq_oe & ~req_lanes & 16'h7FFF) != 16'h0) chk(1'b0, "R6 extra lanes", dq_oe, req_lanes);
      if ((dq_oe & req_lanes) == req_lanes && wcnt > 1 && dq_o == w_dat) dcnt++;
      else if ((dq_oe & req_lanes) == req_lanes) dcnt = 1;
      else dcnt = 0;
      w_dat = dq_o; w_req = req_lanes; w_addr = maddr;
      w_bm = !byte_n; w_lb = !lb_n; w_ub = !ub_n;
    end else if (wcnt > 0) begin
      chk(wcnt >= WPC && wcnt >= AWC, "R5 write pulse", wcnt, AWC);
      chk(dcnt >= DWC, "R5 data setup", dcnt, DWC);
      chk(!cs1_n && (dq_oe & w_req) == w_req && dq_o == w_dat, "R5 release cycle", dq_oe, w_req);
      word = mem.exists(int'(w_addr)) ? mem[int'(w_addr)] : 16'h0;
      if (w_bm) begin
        if (w_dat[15]) word[15:8] = w_dat[7:0];
        else word[7:0] = w_dat[7:0];
      end else begin
        if (w_ub) word[15:8] = w_dat[15:8];
        if (w_lb) word[7:0] = w_dat[7:0];
      end
      mem[int'(w_addr)] = word;
      commits++;
      wcnt = 0;
      dcnt = 0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] d;
    int          acc;
    string       tag;
  } exp_t;
  exp_t        sb[$];
  logic [15:0] shadow [int];

  task automatic access(input bit b, input bit w, input logic [20:0] a,
                        input logic [15:0] d, input logic [1:0] be, input string tag);
    int          acc;
    int          key;
    logic [15:0] word;
    exp_t        e;
    @(negedge clk);
    bm = b; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
    key  = b ? int'(a[20:1]) : int'(a[19:0]);
    word = shadow.exists(key) ? shadow[key] : 16'h0;
    if (w) begin
      if (b) begin
        if (a[0]) word[15:8] = d[7:0];
        else word[7:0] = d[7:0];
      end else begin
        if (be[1]) word[15:8] = d[15:8];
        if (be[0]) word[7:0] = d[7:0];
      end
      shadow[key] = word;
    end else begin
      if (b) e.d = {8'h00, a[0] ? word[15:8] : word[7:0]};
      else e.d = word & {{8{be[1]}}, {8{be[0]}}};
      e.acc = acc;
      e.tag = tag;
      sb.push_back(e);
    end
  endtask

  bit hold_meas = 1'b0;
  int hcnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_meas) begin
        if (!req_ready) hcnt++;
        else begin
          chk(hcnt == TRN, "R8 hold-off length", hcnt, TRN);
          hold_meas = 1'b0;
        end
      end
      if (rsp_valid) begin
        if (sb.size() == 0) chk(1'b0, "R3 unexpected response", rsp_rdata, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_rdata == e.d, e.tag, rsp_rdata, e.d);
          chk(cyc - e.acc == RDC, "R3 read latency", cyc - e.acc, RDC);
          chk(cs2 == 1'b1, "R1 cs2 high", cs2, 1);
        end
        hold_meas = 1'b1;
        hcnt = 1;
      end
    end
  end

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!req_ready || sb.size() != 0 || hold_meas) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(cs1_n && we_n && oe_n && dq_oe == 16'h0 && !rsp_valid, "R1 reset strobes",
        {cs1_n, we_n, oe_n, rsp_valid}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && cs2, "R1 idle ready", {req_ready, cs2}, 2'b11);

    // R3 R4 R5 word write/read, full and partial lanes
    access(0, 1, 21'h00123, 16'hA1B2, 2'b11, "R5 write");
    access(0, 0, 21'h00123, 16'h0, 2'b11, "R3 word read");
    access(0, 0, 21'h00123, 16'h0, 2'b01, "R4 low lane read");
    access(0, 0, 21'h00123, 16'h0, 2'b10, "R4 high lane read");
    access(0, 1, 21'h00123, 16'h77EE, 2'b10, "R6 upper write");
    access(0, 0, 21'h00123, 16'h0, 2'b11, "R6 upper lane only");
    wait_idle();

    // R7 empty lane write
    c0 = commits;
    access(0, 1, 21'h00123, 16'hFFFF, 2'b00, "R7 write");
    wait_idle();
    chk(commits == c0, "R7 no memory write", commits, c0);
    access(0, 0, 21'h00123, 16'h0, 2'b11, "R7 unchanged");

    // R9 byte mode
    access(1, 1, {20'h00456, 1'b1}, 16'h003C, 2'b00, "R9 byte write hi");
    access(1, 1, {20'h00456, 1'b0}, 16'h00C3, 2'b01, "R9 byte write lo");
    access(1, 0, {20'h00456, 1'b1}, 16'h0, 2'b00, "R9 byte read hi");
    access(1, 0, {20'h00456, 1'b0}, 16'h0, 2'b00, "R9 byte read lo");
    access(0, 0, 21'h00456, 16'h0, 2'b11, "R9 word view of bytes");
    access(1, 0, {20'h00123, 1'b1}, 16'h0, 2'b11, "R9 byte read of word data");

    // R10 top request bit ignored in word mode
    access(0, 0, 21'h100123, 16'h0, 2'b11, "R10 top bit ignored");

    // R2 back-to-back at the top of the range
    access(0, 1, 21'h0FFFFF, 16'h1357, 2'b11, "R2 write top");
    access(0, 0, 21'h0FFFFF, 16'h0, 2'b11, "R2 read top");
    access(0, 0, 21'h0FFFFF, 16'h0, 2'b01, "R2 read top low");
    wait_idle();
    chk(commits == 5, "R5 commit count", commits, 5);

    done = 1'b1;
    finish_run();
  end

endmodule